// File: doc/BRIEF.md
# Device Interrupt Mask Router

This block steers level-sensitive device interrupt requests to a small set of processors. A 64-bit pending vector holds one bit per device source; sources are raised and dropped through two narrow strobe-plus-index inputs. Each processor owns a 64-bit enable mask written by software. Its derived request word is always the mask ANDed with the pending vector, and its interrupt line is high while that word is non-zero.

Software talks to the block over a plain register port. It carries a 12-bit byte offset from the block base, 64-bit write data, separate read and write strobes, and a width select for 32-bit or 64-bit access. The normal register file sits on 64-byte strides. Two address flag bits open alternate windows in which the processor number is taken from the address itself. An access the block does not accept sets a sticky error flag and has no other effect.

Top module: `irq_mask_router`

## Requirements
- R1: While reset is low, and after it is released, every mask, the pending vector, every `cpu_irq` bit, `bus_err` and `bus_rdata` are zero.
- R2: In the normal window (offset bits 11 and 10 both zero) the register number is the offset shifted right by 6, and offset bits [5:0] are ignored. Number 0 is the pending vector. Numbers 1 to 4 are the masks of processors 0 to 3. Numbers 5 to 8 are the derived words of processors 0 to 3.
- R3: A read of a processor's derived word returns its mask ANDed with the current pending vector.
- R4: `cpu_irq[c]` is a register equal to the OR of processor c's derived word. It takes its new value on the clock edge that applies a mask write, a post or a clear.
- R5: A post of source n sets pending bit n. A clear of source n drops bit n only when it is set, and leaves the vector alone otherwise. When a post and a clear name the same source in one cycle, the post wins.
- R6: A mask write that enables an already pending source raises that processor's line. A write that removes the last enabled pending bit drops it. Rewriting an unchanged mask leaves the line unchanged.
- R7: Offset bit 10 opens the mask window and offset bit 11 opens the derived window; bit 10 takes precedence. In either window the processor number is offset bits [9:4], and bits [3:0] are ignored. A processor number of 4 or more is an illegal access.
- R8: The pending vector may be read with a 32-bit access (`bus_wide`=0). This returns its low 32 bits with the upper half zero. Every other register accepts only 64-bit access (`bus_wide`=1).
- R9: These are illegal accesses: a wrong width, an unmapped register number, a write to the pending vector or a derived word, and read and write strobed together. Each one sets `bus_err`, which stays set until reset. An illegal write changes no state, and an illegal read returns zero.
- R10: `bus_rdata` is registered. It is loaded on the edge that samples `bus_rd` and holds its value in cycles without a read.
- R11: A mask write and a source post in the same cycle both take effect, and the interrupt line reflects both on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset from the block base |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| src_post | input | 1 | Raise the source named by `src_post_id` |
| src_post_id | input | 6 | Source index to raise |
| src_clr | input | 1 | Drop the source named by `src_clr_id` |
| src_clr_id | input | 6 | Source index to drop |
| cpu_irq | output | 4 | Per-processor device interrupt line |
| bus_err | output | 1 | Sticky illegal-access flag |

## Verification
A software mask write and a device post can land on the same edge. The bench strobes both in one cycle, enabling exactly the bit being posted, and expects the processor's line to rise on that edge; the derived word read back afterwards must show the bit. A post and a clear of the same source are also driven together, and a later read of the pending vector must show the bit still set.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned OFF_W         = 12;
  localparam int unsigned WIN_MASK_BIT  = 10;
  localparam int unsigned WIN_DERIV_BIT = 11;
  localparam int unsigned CPU_FIELD_W   = 6;

  typedef enum logic [1:0] {
    TGT_REQ   = 2'd0,
    TGT_MASK  = 2'd1,
    TGT_DERIV = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e                   tgt;
    logic [CPU_FIELD_W-1:0] cpu;
    logic                   legal_rd;
    logic                   legal_wr;
  } dec_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic [OFF_W-1:0] addr,
  input  logic             wide,
  output dec_t             dec
);

  localparam logic [3:0] LAST_MASK  = 4'(NUM_CPU);
  localparam logic [3:0] LAST_DERIV = 4'(2 * NUM_CPU);

  logic [3:0] idx;
  logic       cpu_ok;
  logic       unused_low;

  assign idx        = addr[9:6];
  assign unused_low = ^addr[3:0];

  always_comb begin
    dec.tgt = TGT_NONE;
    dec.cpu = '0;
    if (addr[WIN_MASK_BIT]) begin
      dec.tgt = TGT_MASK;
      dec.cpu = addr[9:4];
    end else if (addr[WIN_DERIV_BIT]) begin
      dec.tgt = TGT_DERIV;
      dec.cpu = addr[9:4];
    end else if (idx == 4'd0) begin
      dec.tgt = TGT_REQ;
    end else if (idx <= LAST_MASK) begin
      dec.tgt = TGT_MASK;
      dec.cpu = {2'b00, idx - 4'd1};
    end else if (idx <= LAST_DERIV) begin
      dec.tgt = TGT_DERIV;
      dec.cpu = {2'b00, idx - LAST_MASK - 4'd1};
    end
    cpu_ok       = dec.cpu < CPU_FIELD_W'(NUM_CPU);
    dec.legal_rd = (dec.tgt == TGT_REQ) ||
                   (((dec.tgt == TGT_MASK) || (dec.tgt == TGT_DERIV)) && wide && cpu_ok);
    dec.legal_wr = (dec.tgt == TGT_MASK) && wide && cpu_ok;
  end

endmodule

// File: rtl/irq_src_pending.sv
module irq_src_pending #(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post,
  input  logic [ID_W-1:0]    post_id,
  input  logic               clr,
  input  logic [ID_W-1:0]    clr_id,
  output logic [NUM_SRC-1:0] req_next,
  output logic [NUM_SRC-1:0] req_q
);

  always_comb begin
    req_next = req_q;
    if (clr && req_q[clr_id]) req_next[clr_id] = 1'b0;
    if (post)                 req_next[post_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_next;
  end

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [NUM_SRC-1:0] req_next,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               irq_q
);

  logic [NUM_SRC-1:0] mask_next;

  assign mask_next = wr_en ? wr_data : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_next;
      irq_q  <= |(mask_next & req_next);
    end
  end

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFF_W-1:0]   bus_addr,
  input  logic               bus_wide,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic               src_post,
  input  logic [ID_W-1:0]    src_post_id,
  input  logic               src_clr,
  input  logic [ID_W-1:0]    src_clr_id,
  output logic [NUM_CPU-1:0] cpu_irq,
  output logic               bus_err
);

  dec_t                       dec;
  logic                       do_wr;
  logic                       do_rd;
  logic                       bad;
  logic [NUM_SRC-1:0]         req_q;
  logic [NUM_SRC-1:0]         req_next;
  logic [NUM_SRC-1:0]         mask_arr [NUM_CPU];
  logic [NUM_CPU*NUM_SRC-1:0] mask_flat;
  logic [NUM_SRC-1:0]         sel_mask;
  logic [NUM_SRC-1:0]         rd_mux;

  irq_addr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .addr (bus_addr),
    .wide (bus_wide),
    .dec  (dec)
  );

  assign do_wr = bus_wr && !bus_rd && dec.legal_wr;
  assign do_rd = bus_rd && !bus_wr && dec.legal_rd;
  assign bad   = (bus_wr || bus_rd) && !(do_wr || do_rd);

  irq_src_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .post     (src_post),
    .post_id  (src_post_id),
    .clr      (src_clr),
    .clr_id   (src_clr_id),
    .req_next (req_next),
    .req_q    (req_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
    irq_cpu_lane #(.NUM_SRC(NUM_SRC)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (do_wr && (dec.cpu == CPU_FIELD_W'(c))),
      .wr_data  (bus_wdata),
      .req_next (req_next),
      .mask_q   (mask_arr[c]),
      .irq_q    (cpu_irq[c])
    );
    assign mask_flat[c*NUM_SRC +: NUM_SRC] = mask_arr[c];
  end

  always_comb begin
    sel_mask = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (dec.cpu == CPU_FIELD_W'(c)) sel_mask = mask_arr[c];
    end
  end

  always_comb begin
    case (dec.tgt)
      TGT_REQ:   rd_mux = bus_wide ? req_q : {{(NUM_SRC-32){1'b0}}, req_q[31:0]};
      TGT_MASK:  rd_mux = sel_mask;
      TGT_DERIV: rd_mux = sel_mask & req_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= do_rd ? rd_mux : '0;
      if (bad)    bus_err   <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_mask_router_chk.sv
module irq_mask_router_chk #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_rd,
  input logic [NUM_SRC-1:0]         bus_rdata,
  input logic                       bus_err,
  input logic                       src_post,
  input logic [ID_W-1:0]            src_post_id,
  input logic                       src_clr,
  input logic [ID_W-1:0]            src_clr_id,
  input logic [NUM_CPU-1:0]         cpu_irq,
  input logic [NUM_SRC-1:0]         req_q,
  input logic [NUM_CPU*NUM_SRC-1:0] mask_flat
);

  logic [NUM_CPU-1:0] exp_irq;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++)
      exp_irq[c] = |(mask_flat[c*NUM_SRC +: NUM_SRC] & req_q);
  end

  // R4: interrupt lines track mask AND pending held in the other registers
  a_r4_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == exp_irq);

  // R9: error flag never drops outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err);

  // R5: a post always leaves the bit set
  a_r5_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
    src_post |=> req_q[$past(src_post_id)]);

  // R5: a clear not overridden by a post leaves the bit low
  a_r5_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr && !(src_post && (src_post_id == src_clr_id))) |=> !req_q[$past(src_clr_id)]);

  // R10: read data only moves on a read
  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind irq_mask_router irq_mask_router_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .bus_err     (bus_err),
  .src_post    (src_post),
  .src_post_id (src_post_id),
  .src_clr     (src_clr),
  .src_clr_id  (src_clr_id),
  .cpu_irq     (cpu_irq),
  .req_q       (req_q),
  .mask_flat   (mask_flat)
);

// File: tb/irq_mask_router_test.sv
`timescale 1ns/1ps
module irq_mask_router_test;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_POST = 3'd2, OP_CLR = 3'd3;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic        wide;
    logic [63:0] data;
    logic [63:0] expv;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{OP_WR,   12'h040, 1'b1, 64'h5,                  64'h0},
    '{OP_POST, 12'h000, 1'b1, 64'd2,                  64'h1},
    '{OP_RD,   12'h140, 1'b1, 64'h0,                  64'h4},
    '{OP_POST, 12'h000, 1'b1, 64'd63,                 64'h1},
    '{OP_WR,   12'h430, 1'b1, 64'h8000000000000000,   64'h9},
    '{OP_RD,   12'h830, 1'b1, 64'h0,                  64'h8000000000000000},
    '{OP_RD,   12'h000, 1'b1, 64'h0,                  64'h8000000000000004},
    '{OP_RD,   12'h000, 1'b0, 64'h0,                  64'h4},
    '{OP_CLR,  12'h000, 1'b1, 64'd2,                  64'h8},
    '{OP_CLR,  12'h000, 1'b1, 64'd2,                  64'h8},
    '{OP_RD,   12'h000, 1'b1, 64'h0,                  64'h8000000000000000},
    '{OP_WR,   12'h100, 1'b1, 64'h0,                  64'h0},
    '{OP_RD,   12'h100, 1'b1, 64'h0,                  64'h0},
    '{OP_WR,   12'h040, 1'b1, 64'h5,                  64'h0},
    '{OP_RD,   12'h407, 1'b1, 64'h0,                  64'h5},
    '{OP_RD,   12'h07F, 1'b1, 64'h0,                  64'h5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wide = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        src_post = 1'b0;
  logic [5:0]  src_post_id = '0;
  logic        src_clr = 1'b0;
  logic [5:0]  src_clr_id = '0;
  logic [3:0]  cpu_irq;
  logic        bus_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_mask_router uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wide(bus_wide),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_post(src_post), .src_post_id(src_post_id), .src_clr(src_clr),
    .src_clr_id(src_clr_id), .cpu_irq(cpu_irq), .bus_err(bus_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    bus_wr = 1'b0; bus_rd = 1'b0; src_post = 1'b0; src_clr = 1'b0;
  endtask

  // called at a negedge; drives one cycle then returns at the next negedge
  task automatic run_op(input logic [2:0] op, input logic [11:0] a, input logic w,
                        input logic [63:0] d);
    bus_addr = a; bus_wide = w; bus_wdata = d;
    case (op)
      OP_WR:   bus_wr = 1'b1;
      OP_RD:   bus_rd = 1'b1;
      OP_POST: begin src_post = 1'b1; src_post_id = d[5:0]; end
      default: begin src_clr = 1'b1; src_clr_id = d[5:0]; end
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 irq after reset", 64'(cpu_irq), 64'h0);
    check("R1 err after reset", 64'(bus_err), 64'h0);
    check("R1 rdata after reset", bus_rdata, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i].op, VEC[i].addr, VEC[i].wide, VEC[i].data);
      if (VEC[i].op == OP_RD)
        check($sformatf("R2 R3 R7 R8 read vec%0d", i), bus_rdata, VEC[i].expv);
      else
        check($sformatf("R4 R5 R6 irq vec%0d", i), 64'(cpu_irq), VEC[i].expv);
    end
    check("R9 no error on legal traffic", 64'(bus_err), 64'h0);

    // R10: read data holds across idle cycles
    @(negedge clk);
    check("R10 rdata holds", bus_rdata, 64'h5);

    // R11: mask write to cpu1 and post of source 7 in the same cycle
    bus_addr = 12'h080; bus_wide = 1'b1; bus_wdata = 64'h80; bus_wr = 1'b1;
    src_post = 1'b1; src_post_id = 6'd7;
    @(negedge clk);
    idle_inputs();
    check("R11 same-cycle mask write and post", 64'(cpu_irq), 64'h2);
    run_op(OP_RD, 12'h180, 1'b1, 64'h0);
    check("R11 R3 derived cpu1", bus_rdata, 64'h80);

    // R5: post and clear of source 9 together, post wins
    src_post = 1'b1; src_post_id = 6'd9; src_clr = 1'b1; src_clr_id = 6'd9;
    @(negedge clk);
    idle_inputs();
    run_op(OP_RD, 12'h000, 1'b1, 64'h0);
    check("R5 post beats clear", bus_rdata, 64'h8000000000000280);

    // R6: removing the enabled bit drops the line
    run_op(OP_WR, 12'h080, 1'b1, 64'h0);
    check("R6 mask removal drops irq", 64'(cpu_irq), 64'h0);

    // R9: narrow write to a mask is dropped and flagged
    run_op(OP_WR, 12'h040, 1'b0, 64'hFF);
    check("R9 err on narrow write", 64'(bus_err), 64'h1);
    run_op(OP_RD, 12'h040, 1'b1, 64'h0);
    check("R8 R9 mask0 unchanged", bus_rdata, 64'h5);

    // R9: write to the pending vector is dropped
    run_op(OP_WR, 12'h000, 1'b1, 64'h0);
    run_op(OP_RD, 12'h000, 1'b1, 64'h0);
    check("R9 pending unchanged by write", bus_rdata, 64'h8000000000000280);

    // R9: unmapped register number reads zero
    run_op(OP_RD, 12'h240, 1'b1, 64'h0);
    check("R9 unmapped read zero", bus_rdata, 64'h0);

    // R7: window processor number out of range
    run_op(OP_RD, 12'h000, 1'b1, 64'h0);
    run_op(OP_RD, 12'h450, 1'b1, 64'h0);
    check("R7 window cpu5 reads zero", bus_rdata, 64'h0);
    check("R9 err stays set", 64'(bus_err), 64'h1);

    // R1: reset in mid-run clears everything
    do_reset();
    check("R1 err cleared by reset", 64'(bus_err), 64'h0);
    check("R1 irq cleared by reset", 64'(cpu_irq), 64'h0);
    run_op(OP_RD, 12'h000, 1'b1, 64'h0);
    check("R1 pending cleared", bus_rdata, 64'h0);
    run_op(OP_RD, 12'h040, 1'b1, 64'h0);
    check("R1 mask0 cleared", bus_rdata, 64'h0);

    finish_run();
  end

endmodule